// File: doc/BRIEF.md
# Dual-Clock Calibration Counter Unit

This unit measures how many edges of a fast, high-resolution clock fit into a programmable number of system-clock cycles. After software starts a calibration run, a system-side counter steps from zero up to the programmed period. During the same run, a fast-side counter keeps counting in its own clock domain. When the run ends, both counts are frozen into capture registers. Software divides one capture by the other to obtain the clock ratio.

The fast count crosses into the system domain as a Gray code through two synchronizing flops. The system side stores the synchronized value seen at the start of a run. The elapsed fast count is the difference between that stored value and the current synchronized value. If that elapsed count reaches the counter range before the period match, the run ends early and a separate status flag is raised in place of the done flag. A continuous mode starts each new run on the cycle after the previous one ends.

The register file is on the system clock. It holds control, period, counters, captures and four interrupt registers: enable, flag, clear and force. One interrupt output pulses when the global interrupt flag rises. The global flag blocks further pulses until software clears it.

Top module: `calib_ctr_unit`

## Requirements
- R1: After reset every register reads zero except the period, which reads `PRD_INIT`. The `irq` output is low.
- R2: Address map (byte offsets):
  - 0x00 control
  - 0x04 enable
  - 0x06 flags
  - 0x08 clear
  - 0x0A force
  - 0x0C period
  - 0x0E system counter
  - 0x10 system capture
  - 0x12 fast counter
  - 0x14 fast capture
- R2 (continued): Any other offset reads zero and ignores writes. The clear and force registers read zero. Control bit 3 (start) reads zero.
- R3: A run lasts period+1 system cycles, with the system counter going 0..P. On the match cycle the system capture takes P and flag bit 1 (done) is set.
- R4: A write of 1 to control bit 3 starts a run and sets control bit 4 (busy). The start is ignored when control bit 1 (fast clock enable) was 0 before that write, and also while a run is busy.
- R5: With control bit 5 (continuous) at 0, busy falls when the run ends. With it at 1, the system counter restarts at 0 on the next cycle with no idle gap.
- R6: If the elapsed fast count reaches 2^CNT_W before the period match, the run ends early. Flag bit 2 (period check) is set, the done flag is not, and both counts are captured.
- R7: The fast capture equals the number of fast-clock edges between the run start and the run end, within a few edges of synchronizer latency. The fast value crosses domains only in Gray code.
- R8: Flags stay set until software writes 1 to the same bit of the clear register. A hardware set and a software clear of the same flag in the same cycle leave the flag set.
- R9: Writing 1 to force bit 1 or bit 2 sets the done or period-check flag.
- R10: The global flag (flag bit 0) sets one cycle after an enabled event flag is set. `irq` is a one-cycle pulse in the first cycle the global flag is high. While the global flag stays set, no further pulse occurs. Clearing it (clear bit 0) with an enabled event flag still pending raises it again with a new pulse.
- R11: Enable bit 1 enables done and enable bit 2 enables period-check. A flag whose enable is 0 does not set the global flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; register file and run control |
| fast_clk | input | 1 | High-resolution clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the unit with an 8-bit counter width and a reset period of 200. It runs the fast clock at four times the system clock. With these values an early end by fast-counter overflow happens after about 64 system cycles, so the period-check path is reached in a short run. The default period can still be checked against the reset value. A short period of 10 or 20 cycles lets the bench walk several continuous runs. In those runs it places a software clear exactly on the match cycle and tracks each interrupt pulse against a behavioural model.

// File: rtl/calib_pkg.sv
package calib_pkg;
    localparam int ADDR_W = 5;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_IEN  = 5'h04;
    localparam logic [ADDR_W-1:0] A_FLG  = 5'h06;
    localparam logic [ADDR_W-1:0] A_CLR  = 5'h08;
    localparam logic [ADDR_W-1:0] A_FRC  = 5'h0A;
    localparam logic [ADDR_W-1:0] A_PRD  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_SCTR = 5'h0E;
    localparam logic [ADDR_W-1:0] A_SCAP = 5'h10;
    localparam logic [ADDR_W-1:0] A_FCTR = 5'h12;
    localparam logic [ADDR_W-1:0] A_FCAP = 5'h14;

    // control bit positions
    localparam int C_HRE   = 0;
    localparam int C_FCLK  = 1;
    localparam int C_PSEL  = 2;
    localparam int C_START = 3;
    localparam int C_BUSY  = 4;
    localparam int C_CONT  = 5;

    // flag / enable / clear / force bit positions
    localparam int F_GLB  = 0;
    localparam int F_DONE = 1;
    localparam int F_PCHK = 2;
endpackage

// File: rtl/calib_fast_ctr.sv
module calib_fast_ctr #(
    parameter int W = 33
) (
    input  logic         fclk,
    input  logic         rst_n,
    input  logic         en_async,
    output logic [W-1:0] gray_o
);
    logic [1:0]   en_sync_q, en_sync_d;
    logic [W-1:0] bin_q, bin_d;
    logic [W-1:0] gray_q, gray_d;

    always_comb begin
        en_sync_d = {en_sync_q[0], en_async};
        bin_d     = en_sync_q[1] ? bin_q + 1'b1 : bin_q;
        gray_d    = bin_q ^ (bin_q >> 1);
    end

    always_ff @(posedge fclk or negedge rst_n) begin
        if (!rst_n) begin
            en_sync_q <= '0;
            bin_q     <= '0;
            gray_q    <= '0;
        end else begin
            en_sync_q <= en_sync_d;
            bin_q     <= bin_d;
            gray_q    <= gray_d;
        end
    end

    assign gray_o = gray_q;

    AST_GRAY_ONE_STEP: assert property (@(posedge fclk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1); // R7
endmodule

// File: rtl/calib_gray_sync.sv
module calib_gray_sync #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    logic [W-1:0] s1_q, s1_d, s2_q, s2_d;

    always_comb begin
        s1_d = gray_i;
        s2_d = s1_q;
        for (int i = 0; i < W; i++) begin
            bin_o[i] = ^(s2_q >> i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end
endmodule

// File: rtl/calib_irq.sv
module calib_irq
    import calib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_done,
    input  logic       set_pchk,
    input  logic [2:0] clr,
    input  logic       en_done,
    input  logic       en_pchk,
    output logic [2:0] flags_o,
    output logic       irq_o
);
    typedef struct packed {
        logic done;
        logic pchk;
        logic glb;
        logic irq;
    } irq_state_t;

    irq_state_t q, d;
    logic pending;

    always_comb begin
        d       = q;
        pending = (q.done && en_done) || (q.pchk && en_pchk);
        // a hardware set outranks a same-cycle software clear
        if (set_done)          d.done = 1'b1;
        else if (clr[F_DONE])  d.done = 1'b0;
        if (set_pchk)          d.pchk = 1'b1;
        else if (clr[F_PCHK])  d.pchk = 1'b0;
        if (q.glb && clr[F_GLB])   d.glb = 1'b0;
        else if (!q.glb && pending) d.glb = 1'b1;
        d.irq = d.glb && !q.glb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flags_o = {q.pchk, q.done, q.glb};
    assign irq_o   = q.irq;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq); // R10
    AST_GLOBAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.glb && !clr[F_GLB]) |=> q.glb); // R10
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> q.done); // R8
    AST_MASKED_NO_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.glb && !(q.done && en_done) && !(q.pchk && en_pchk)) |=> !q.glb); // R11
endmodule

// File: rtl/calib_ctr_unit.sv
module calib_ctr_unit
    import calib_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] PRD_INIT = CNT_W'(32'h003F_FFFF)
) (
    input  logic              sys_clk,
    input  logic              fast_clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int EW = CNT_W + 1;

    typedef struct packed {
        logic             hre;
        logic             fclk_en;
        logic             psel;
        logic             cont;
        logic             busy;
        logic             en_done;
        logic             en_pchk;
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] sctr;
        logic [CNT_W-1:0] scap;
        logic [CNT_W-1:0] fcap;
        logic [EW-1:0]    base;
    } unit_state_t;

    unit_state_t q, d;

    logic [EW-1:0] fast_gray, fast_bin, elapsed;
    logic          wr_ctrl, wr_ien, wr_clr, wr_frc, wr_prd;
    logic          match, ovf, fin;
    logic          set_done, set_pchk;
    logic [2:0]    clr_bits;
    logic [2:0]    flags;

    calib_fast_ctr #(.W(EW)) u_fast (
        .fclk     (fast_clk),
        .rst_n    (rst_n),
        .en_async (q.fclk_en),
        .gray_o   (fast_gray)
    );

    calib_gray_sync #(.W(EW)) u_sync (
        .clk    (sys_clk),
        .rst_n  (rst_n),
        .gray_i (fast_gray),
        .bin_o  (fast_bin)
    );

    calib_irq u_irq (
        .clk      (sys_clk),
        .rst_n    (rst_n),
        .set_done (set_done),
        .set_pchk (set_pchk),
        .clr      (clr_bits),
        .en_done  (q.en_done),
        .en_pchk  (q.en_pchk),
        .flags_o  (flags),
        .irq_o    (irq)
    );

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
        wr_ien   = bus_wr && (bus_addr == A_IEN);
        wr_clr   = bus_wr && (bus_addr == A_CLR);
        wr_frc   = bus_wr && (bus_addr == A_FRC);
        wr_prd   = bus_wr && (bus_addr == A_PRD);

        elapsed  = fast_bin - q.base;
        match    = q.busy && (q.sctr == q.prd);
        ovf      = q.busy && !match && elapsed[CNT_W];
        fin      = match || ovf;

        set_done = match || (wr_frc && bus_wdata[F_DONE]);
        set_pchk = ovf   || (wr_frc && bus_wdata[F_PCHK]);
        clr_bits = wr_clr ? bus_wdata[2:0] : 3'b000;

        d = q;
        if (fin) begin
            d.scap = q.sctr;
            d.fcap = elapsed[CNT_W-1:0];
            d.sctr = '0;
            d.base = fast_bin;
            d.busy = q.cont;
        end else if (q.busy) begin
            d.sctr = q.sctr + 1'b1;
        end else if (wr_ctrl && bus_wdata[C_START] && q.fclk_en) begin
            d.busy = 1'b1;
            d.sctr = '0;
            d.base = fast_bin;
        end

        if (wr_ctrl) begin
            d.hre     = bus_wdata[C_HRE];
            d.fclk_en = bus_wdata[C_FCLK];
            d.psel    = bus_wdata[C_PSEL];
            d.cont    = bus_wdata[C_CONT];
        end
        if (wr_ien) begin
            d.en_done = bus_wdata[F_DONE];
            d.en_pchk = bus_wdata[F_PCHK];
        end
        if (wr_prd) d.prd = bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.prd <= PRD_INIT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[C_HRE]  = q.hre;
                bus_rdata[C_FCLK] = q.fclk_en;
                bus_rdata[C_PSEL] = q.psel;
                bus_rdata[C_BUSY] = q.busy;
                bus_rdata[C_CONT] = q.cont;
            end
            A_IEN: begin
                bus_rdata[F_DONE] = q.en_done;
                bus_rdata[F_PCHK] = q.en_pchk;
            end
            A_FLG:  bus_rdata[2:0] = flags;
            A_PRD:  bus_rdata = BUS_W'(q.prd);
            A_SCTR: bus_rdata = BUS_W'(q.sctr);
            A_SCAP: bus_rdata = BUS_W'(q.scap);
            A_FCTR: bus_rdata = BUS_W'(elapsed[CNT_W-1:0]);
            A_FCAP: bus_rdata = BUS_W'(q.fcap);
            default: bus_rdata = '0;
        endcase
    end

    AST_START_NEEDS_FCLK: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[C_START] && !q.fclk_en && !q.busy) |=> !q.busy); // R4
    AST_CAPTURE_IS_PRD: assert property (@(posedge sys_clk) disable iff (!rst_n)
        match |=> (q.scap == $past(q.prd))); // R3
    AST_ONESHOT_STOPS: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (fin && !q.cont) |=> !q.busy); // R5
    AST_CONT_RESTARTS: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (fin && q.cont) |=> (q.busy && q.sctr == '0)); // R5
    AST_OVF_SETS_PCHK: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ovf |=> flags[F_PCHK]); // R6
    AST_MATCH_SETS_DONE: assert property (@(posedge sys_clk) disable iff (!rst_n)
        match |=> flags[F_DONE]); // R8
endmodule

// File: tb/calib_ctr_unit_test.sv
`timescale 1ns/1ps
module calib_ctr_unit_test;
    import calib_pkg::*;

    localparam int CW = 8;
    localparam logic [CW-1:0] PINIT = 8'hC8;

    logic        sys_clk = 1'b0;
    logic        fast_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = A_FLG;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int irq_cnt = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    bit m_fclk, m_cont, m_busy, m_en_d, m_en_p, m_done, m_pchk, m_glb, m_irq;
    int m_prd, m_sctr, m_scap;

    calib_ctr_unit #(.CNT_W(CW), .PRD_INIT(PINIT)) uut (
        .sys_clk   (sys_clk),
        .fast_clk  (fast_clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #5 sys_clk = ~sys_clk;
    initial begin
        #0.3;
        forever #1.25 fast_clk = ~fast_clk;
    end

    always @(posedge sys_clk or negedge rst_n) begin
        bit o_glb, o_done, o_pchk, mt, wc, wf, wt, wi, wp, sd, sp;
        if (!rst_n) begin
            m_fclk = 0; m_cont = 0; m_busy = 0; m_en_d = 0; m_en_p = 0;
            m_done = 0; m_pchk = 0; m_glb = 0; m_irq = 0;
            m_prd = int'(PINIT); m_sctr = 0; m_scap = 0;
        end else if (model_on) begin
            o_glb = m_glb; o_done = m_done; o_pchk = m_pchk;
            wt = bus_wr && bus_addr == 5'h00;
            wi = bus_wr && bus_addr == 5'h04;
            wc = bus_wr && bus_addr == 5'h08;
            wf = bus_wr && bus_addr == 5'h0A;
            wp = bus_wr && bus_addr == 5'h0C;
            mt = m_busy && (m_sctr == m_prd);
            sd = mt || (wf && bus_wdata[1]);
            sp = wf && bus_wdata[2];
            if (sd) m_done = 1; else if (wc && bus_wdata[1]) m_done = 0;
            if (sp) m_pchk = 1; else if (wc && bus_wdata[2]) m_pchk = 0;
            if (o_glb && wc && bus_wdata[0]) m_glb = 0;
            else if (!o_glb && ((o_done && m_en_d) || (o_pchk && m_en_p))) m_glb = 1;
            m_irq = !o_glb && m_glb;
            if (mt) begin
                m_scap = m_sctr; m_sctr = 0; m_busy = m_cont;
            end else if (m_busy) begin
                m_sctr = m_sctr + 1;
            end else if (wt && bus_wdata[3] && m_fclk) begin
                m_busy = 1; m_sctr = 0;
            end
            if (wt) begin m_fclk = bus_wdata[1]; m_cont = bus_wdata[5]; end
            if (wi) begin m_en_d = bus_wdata[1]; m_en_p = bus_wdata[2]; end
            if (wp) m_prd = int'(bus_wdata[CW-1:0]);
        end
    end

    // per-clock comparison of the interrupt pin against the model (R10)
    always @(negedge sys_clk) begin
        if (rst_n) begin
            if (irq) irq_cnt++;
            if (model_on) begin
                n_chk++;
                if (irq !== m_irq) begin
                    n_err++;
                    $display("FAIL R10 irq actual=%0b expected=%0b at %0t", irq, m_irq, $time);
                end
            end
        end
    end

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // called at a falling edge; the write takes effect at the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge sys_clk);
        bus_wr = 1'b0; bus_addr = A_FLG; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = A_FLG;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    function automatic logic [31:0] m_flags();
        return {29'd0, m_pchk, m_done, m_glb};
    endfunction

    task automatic wait_idle(output int busy_cycles);
        logic [31:0] v;
        busy_cycles = 0;
        for (int k = 0; k < 1000; k++) begin
            rd(A_CTRL, v);
            if (!v[4]) break;
            busy_cycles++;
            @(negedge sys_clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int bc, ic0;
        tick(4);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R1 reset values
        rd(A_CTRL, v); expect_eq("R1 ctrl", v, 0);
        rd(A_FLG, v);  expect_eq("R1 flags", v, 0);
        rd(A_PRD, v);  expect_eq("R1 period", v, 32'(PINIT));
        rd(A_SCTR, v); expect_eq("R1 sys counter", v, 0);
        rd(A_SCAP, v); expect_eq("R1 sys capture", v, 0);
        rd(A_FCAP, v); expect_eq("R1 fast capture", v, 0);
        expect_eq("R1 irq", 32'(irq), 0);

        // R2 unmapped and write-only locations
        wr(5'h02, 32'hFFFF_FFFF);
        rd(5'h02, v);  expect_eq("R2 unmapped 0x02", v, 0);
        rd(5'h16, v);  expect_eq("R2 unmapped 0x16", v, 0);
        rd(A_CTRL, v); expect_eq("R2 ctrl untouched", v, 0);
        rd(A_CLR, v);  expect_eq("R2 clear reads 0", v, 0);
        rd(A_FRC, v);  expect_eq("R2 force reads 0", v, 0);

        // R4 start ignored while fast clock enable is low
        wr(A_CTRL, 32'h08);
        rd(A_CTRL, v); expect_eq("R4 start without fclk", v, 0);
        wr(A_CTRL, 32'h0A);
        rd(A_CTRL, v); expect_eq("R4 start with fclk in same write", v, 32'h02);
        tick(4);

        // R3 / R5 / R7 one-shot run with period 20
        wr(A_IEN, 32'h2);
        wr(A_PRD, 32'd20);
        ic0 = irq_cnt;
        wr(A_CTRL, 32'h0A);
        rd(A_CTRL, v); expect_eq("R2 R4 busy set, start reads 0", v, 32'h12);
        wr(A_CTRL, 32'h0A);
        wait_idle(bc);
        expect_eq("R3 run length", bc, 20);
        rd(A_SCAP, v); expect_eq("R3 sys capture", v, 20);
        rd(A_FCAP, v); expect_rng("R7 fast capture", int'(v), 80, 88);
        tick(3);
        rd(A_FLG, v);  expect_eq("R8 R10 flags sticky", v, 32'h3);
        expect_eq("R10 flags vs model", v, m_flags());
        expect_eq("R10 one pulse", irq_cnt - ic0, 1);
        rd(A_CTRL, v); expect_eq("R5 busy low", v, 32'h02);

        // R8 clear, then clear collides with match
        wr(A_CLR, 32'h7);
        rd(A_FLG, v);  expect_eq("R8 cleared", v, 0);
        wr(A_CTRL, 32'h0A);
        for (int k = 0; k < 100; k++) begin
            if (m_busy && m_sctr == m_prd) break;
            @(negedge sys_clk);
        end
        wr(A_CLR, 32'h2);
        rd(A_FLG, v);  expect_eq("R8 hw set wins", v[1], 1'b1);
        expect_eq("R8 flags vs model", v, m_flags());
        tick(2);
        wr(A_CLR, 32'h7);
        wr(A_IEN, 32'h0);
        tick(2);

        // R9 / R11 force with masking
        ic0 = irq_cnt;
        wr(A_FRC, 32'h4);
        tick(2);
        rd(A_FLG, v);  expect_eq("R9 R11 pchk forced, masked", v, 32'h4);
        expect_eq("R11 no pulse when masked", irq_cnt - ic0, 0);
        wr(A_IEN, 32'h4);
        tick(2);
        rd(A_FLG, v);  expect_eq("R11 enable raises global", v, 32'h5);
        expect_eq("R10 pulse on enable", irq_cnt - ic0, 1);
        wr(A_FRC, 32'h2);
        tick(2);
        rd(A_FLG, v);  expect_eq("R9 done forced", v, 32'h7);
        expect_eq("R10 blocked while global set", irq_cnt - ic0, 1);

        // R10 re-arm by clearing only the global flag
        wr(A_CLR, 32'h1);
        tick(2);
        rd(A_FLG, v);  expect_eq("R10 global re-raised", v, 32'h7);
        expect_eq("R10 second pulse", irq_cnt - ic0, 2);
        wr(A_CLR, 32'h6);
        wr(A_CLR, 32'h1);
        tick(2);
        rd(A_FLG, v);  expect_eq("R8 all cleared", v, 0);
        expect_eq("R10 no pulse after full clear", irq_cnt - ic0, 2);

        // R5 continuous mode with period 10
        wr(A_IEN, 32'h2);
        wr(A_PRD, 32'd10);
        ic0 = irq_cnt;
        wr(A_CTRL, 32'h2A);
        for (int k = 0; k < 30; k++) begin
            rd(A_SCTR, v);
            expect_eq("R5 continuous counter", v, 32'(m_sctr));
            @(negedge sys_clk);
        end
        rd(A_CTRL, v); expect_eq("R5 still busy", v, 32'h32);
        expect_eq("R10 one pulse over repeated runs", irq_cnt - ic0, 1);
        wr(A_CTRL, 32'h02);
        wait_idle(bc);
        expect_rng("R5 stops at next match", bc, 0, 11);
        rd(A_SCAP, v); expect_eq("R3 continuous capture", v, 10);
        wr(A_CLR, 32'h7);
        wr(A_IEN, 32'h0);

        // R6 fast overflow ends the run early
        model_on = 1'b0;
        wr(A_PRD, 32'd200);
        wr(A_CTRL, 32'h0A);
        wait_idle(bc);
        expect_rng("R6 early end", bc, 58, 70);
        tick(2);
        rd(A_FLG, v);  expect_eq("R6 pchk not done", v & 32'h6, 32'h4);
        rd(A_SCAP, v); expect_rng("R6 sys capture", int'(v), 57, 69);
        rd(A_FCAP, v); expect_rng("R6 fast capture wrapped", int'(v), 0, 7);

        finish_run();
    end
endmodule